// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block samples a bank of 32 asynchronous digital input lines and raises one level interrupt when the low 16 lines meet a programmable change-of-state rule. Software reaches it through a small 32-bit register bus with separate write and read strobes. Through that bus it can read the live input lines, program two channel masks, pick the combining rule and the global enable, and collect the channels that caused the interrupt.

Two combining rules are available. In the any-edge rule, each selected channel watches for a rising edge, a falling edge or both, and any one of them fires. In the all-levels rule, each selected channel must be high or low, and the interrupt fires only when every selected channel meets its level at once. After such a firing the rule must first stop being met before it can fire again. Reading the capture register hands back the triggering channels and clears them along with the interrupt. Every input passes through a two-flop synchroniser before any use.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: A read strobe at offset 0x00 returns the synchronised value of all 32 input lines. Read data appears on `bus_rdata` with `bus_rvalid` high on the cycle after the strobe.
- R3: The rise mask is at offset 0x04 and the fall mask at offset 0x08. Each keeps only bits 15:0, and bits 31:16 read back as zero. The control register is at 0x10: bit 1 selects the rule (0 = any-edge, 1 = all-levels) and bit 2 is the enable. All its other bits read as zero.
- R4: Any-edge rule with enable set: a 0-to-1 change on a channel whose rise-mask bit is set, or a 1-to-0 change on a channel whose fall-mask bit is set, sets that channel's bit in the capture register (offset 0x0C, bits 15:0) and raises `irq`. A channel with both mask bits set fires on either edge.
- R5: While `irq` is high, further any-edge events are added into the capture bits, and `irq` stays high.
- R6: All-levels rule with enable set: a channel is selected when its rise-mask bit (wants high) or fall-mask bit (wants low) is set. When at least one channel is selected and every selected channel meets its level, the capture register takes the selected set and `irq` rises.
- R7: After an all-levels firing, no further interrupt comes while the condition stays met. It can fire again only once the condition has been broken and met anew, or once the control register has been written.
- R8: A read of the capture register returns its bits 15:0 with bits 31:16 as zero, then clears the capture bits and drops `irq`. An event found in the same cycle as the read is kept for the next read.
- R9: Writing the control register with the enable bit clear drops `irq`, clears the capture bits and blocks all new events.
- R10: Lines 16 to 31 never cause an interrupt. With both masks zero, no input activity causes one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous release assumed |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High on the cycle after a read strobe |
| din | input | 32 | Asynchronous digital input lines |
| irq | output | 1 | Level interrupt request |

## Verification
The bench targets the read that lands on the same cycle as a new edge. A design that lets the clear win there silently loses an event. It holds an all-levels condition true after a read; a design without the re-arm guard would raise `irq` again at once. It toggles only lines 16 to 31 with full masks written, which a design decoding too many channels would turn into an interrupt. It sets both mask bits on one channel, where a priority-coded detector would miss one of the two edges. It also checks that an event arriving while `irq` is high is merged into the capture rather than overwriting it.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam logic [4:0] OFF_RAW  = 5'h00;
  localparam logic [4:0] OFF_RISE = 5'h04;
  localparam logic [4:0] OFF_FALL = 5'h08;
  localparam logic [4:0] OFF_CAPT = 5'h0C;
  localparam logic [4:0] OFF_CTRL = 5'h10;
  localparam int CTRL_RULE_BIT = 1;
  localparam int CTRL_EN_BIT   = 2;

  typedef enum logic {RULE_ANY_EDGE = 1'b0, RULE_ALL_LEVEL = 1'b1} rule_e;
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d[b]};
    end
    assign q[b] = shreg[STAGES-1];
  end
endmodule

// File: rtl/cos_detect.sv
module cos_detect #(
  parameter int N = 16
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] prev,
  input  logic [N-1:0] rise_mask,
  input  logic [N-1:0] fall_mask,
  output logic [N-1:0] edge_hit,
  output logic [N-1:0] sel,
  output logic         all_met
);
  logic [N-1:0] lvl_ok;

  for (genvar c = 0; c < N; c++) begin : g_ch
    logic went_up, went_down;
    assign went_up     = cur[c] & ~prev[c];
    assign went_down   = ~cur[c] & prev[c];
    assign edge_hit[c] = (rise_mask[c] & went_up) | (fall_mask[c] & went_down);
    assign sel[c]      = rise_mask[c] | fall_mask[c];
    // unselected channels count as satisfied
    assign lvl_ok[c]   = ~sel[c] | (rise_mask[c] & cur[c]) | (fall_mask[c] & ~cur[c]);
  end

  assign all_met = (|sel) & (&lvl_ok);
endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl #(
  parameter int DATA_W      = 32,
  parameter int IRQ_CH      = 16,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [DATA_W-1:0] din,
  output logic              irq
);
  import cos_pkg::*;

  localparam int PAD_W = DATA_W - IRQ_CH;

  // address decode
  logic hit_raw, hit_rise, hit_fall, hit_capt, hit_ctrl;
  assign hit_raw  = bus_addr == ADDR_W'(OFF_RAW);
  assign hit_rise = bus_addr == ADDR_W'(OFF_RISE);
  assign hit_fall = bus_addr == ADDR_W'(OFF_FALL);
  assign hit_capt = bus_addr == ADDR_W'(OFF_CAPT);
  assign hit_ctrl = bus_addr == ADDR_W'(OFF_CTRL);

  logic wr_rise, wr_fall, wr_ctrl, rd_capt;
  assign wr_rise = bus_wr & hit_rise;
  assign wr_fall = bus_wr & hit_fall;
  assign wr_ctrl = bus_wr & hit_ctrl;
  assign rd_capt = bus_rd & hit_capt;

  // input path
  logic [DATA_W-1:0] din_s;
  logic [IRQ_CH-1:0] ch_prev;

  cos_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(din), .q(din_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ch_prev <= '0;
    else        ch_prev <= din_s[IRQ_CH-1:0];
  end

  // configuration
  logic [IRQ_CH-1:0] rise_mask, fall_mask;
  logic              ctrl_en;
  rule_e             ctrl_rule;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_mask <= '0;
      fall_mask <= '0;
      ctrl_en   <= 1'b0;
      ctrl_rule <= RULE_ANY_EDGE;
    end else begin
      if (wr_rise) rise_mask <= bus_wdata[IRQ_CH-1:0];
      if (wr_fall) fall_mask <= bus_wdata[IRQ_CH-1:0];
      if (wr_ctrl) begin
        ctrl_en   <= bus_wdata[CTRL_EN_BIT];
        ctrl_rule <= rule_e'(bus_wdata[CTRL_RULE_BIT]);
      end
    end
  end

  logic wdata_unused;
  assign wdata_unused = ^{bus_wdata[DATA_W-1:CTRL_EN_BIT+1], bus_wdata[0]};

  // condition evaluation
  logic [IRQ_CH-1:0] edge_hit, sel;
  logic              all_met;

  cos_detect #(.N(IRQ_CH)) u_detect (
    .cur(din_s[IRQ_CH-1:0]), .prev(ch_prev),
    .rise_mask(rise_mask), .fall_mask(fall_mask),
    .edge_hit(edge_hit), .sel(sel), .all_met(all_met)
  );

  // capture and interrupt
  logic              armed;
  logic              level_fire;
  logic              hit_any;
  logic [IRQ_CH-1:0] new_bits;
  logic [IRQ_CH-1:0] status_q;
  logic              pend_q;
  logic              disable_wr;

  assign level_fire = ctrl_en & (ctrl_rule == RULE_ALL_LEVEL) & all_met & armed;
  assign hit_any    = |edge_hit;
  assign disable_wr = wr_ctrl & ~bus_wdata[CTRL_EN_BIT];

  always_comb begin
    new_bits = '0;
    if (ctrl_en && ctrl_rule == RULE_ANY_EDGE) new_bits = edge_hit;
    if (level_fire)                            new_bits = sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b1;
    else if (wr_ctrl)    armed <= 1'b1;
    else if (level_fire) armed <= 1'b0;
    else if (!all_met)   armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pend_q   <= 1'b0;
    end else if (disable_wr) begin
      status_q <= '0;
      pend_q   <= 1'b0;
    end else if (rd_capt) begin
      status_q <= new_bits;
      pend_q   <= |new_bits;
    end else begin
      status_q <= status_q | new_bits;
      pend_q   <= pend_q | (|new_bits);
    end
  end

  assign irq = pend_q;

  // read port
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit_raw:  rd_mux = din_s;
      hit_rise: rd_mux = {{PAD_W{1'b0}}, rise_mask};
      hit_fall: rd_mux = {{PAD_W{1'b0}}, fall_mask};
      hit_capt: rd_mux = {{PAD_W{1'b0}}, status_q};
      hit_ctrl: begin
        rd_mux[CTRL_EN_BIT]   = ctrl_en;
        rd_mux[CTRL_RULE_BIT] = ctrl_rule;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/cos_irq_chk.sv
module cos_irq_chk #(
  parameter int DATA_W = 32,
  parameter int IRQ_CH = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic              irq,
  input logic              en,
  input logic [IRQ_CH-1:0] status,
  input logic              hit_any,
  input logic              all_met
);
  import cos_pkg::*;

  assert_rvalid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);

  assert_mask_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && (bus_addr == ADDR_W'(OFF_RISE) || bus_addr == ADDR_W'(OFF_FALL))
      |=> bus_rdata[DATA_W-1:IRQ_CH] == '0);

  assert_irq_has_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status != '0);

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == ADDR_W'(OFF_CAPT) && !hit_any && !all_met
      |=> !irq && status == '0);

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> en);

  assert_rise_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(hit_any) || $past(all_met));
endmodule

bind cos_irq_ctrl cos_irq_chk #(.DATA_W(DATA_W), .IRQ_CH(IRQ_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq),
  .en(ctrl_en), .status(status_q), .hit_any(hit_any), .all_met(all_met)
);

// File: tb/cos_irq_ctrl_bench.sv
module cos_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, din = '0;
  logic        bus_rvalid, irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  localparam logic [4:0] A_RAW = 5'h00, A_RISE = 5'h04, A_FALL = 5'h08,
                         A_CAPT = 5'h0C, A_CTRL = 5'h10;
  localparam logic [31:0] C_OFF = 32'h0, C_EDGE = 32'h4, C_LEVEL = 32'h6;

  always #4 clk = ~clk;

  cos_irq_ctrl u_cos_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .din(din), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  function automatic logic [15:0] edge_exp(input logic [15:0] m1, m2, a, b);
    return (m1 & b & ~a) | (m2 & a & ~b);
  endfunction

  function automatic logic level_exp(input logic [15:0] m1, m2, d);
    logic [15:0] s, ok;
    s  = m1 | m2;
    ok = (m1 & d) | (m2 & ~d);
    return (s != 0) && ((ok & s) == s);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_C05));
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    rd(A_RISE, v); chk("R1 rise", v, 0);
    rd(A_FALL, v); chk("R1 fall", v, 0);
    rd(A_CAPT, v); chk("R1 capt", v, 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);

    // R2 raw input mirror, all 32 lines
    din = 32'hA5C3_0F96; idle(4);
    @(negedge clk); bus_rd = 1'b1; bus_addr = A_RAW;
    @(negedge clk); bus_rd = 1'b0;
    chk("R2 rvalid", {31'b0, bus_rvalid}, 1);
    chk("R2 raw", bus_rdata, 32'hA5C3_0F96);

    // R3 field widths
    wr(A_RISE, 32'hFFFF_FFFF); rd(A_RISE, v); chk("R3 rise", v, 32'h0000_FFFF);
    wr(A_FALL, 32'h1234_8001); rd(A_FALL, v); chk("R3 fall", v, 32'h0000_8001);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); chk("R3 ctrl", v, 32'h6);
    wr(A_CTRL, C_OFF);

    // R10 upper lines never interrupt
    wr(A_RISE, 32'hFFFF_FFFF); wr(A_FALL, 32'hFFFF_FFFF);
    din = 32'h0000_0000; idle(5);
    wr(A_CTRL, C_EDGE); idle(3);
    for (int i = 0; i < 6; i++) begin
      din[31:16] = 16'($urandom); idle(2);
    end
    idle(4);
    chk("R10 upper lines irq", {31'b0, irq}, 0);
    rd(A_CAPT, v); chk("R10 upper lines capt", v, 0);

    // R10 zero masks
    wr(A_RISE, 0); wr(A_FALL, 0);
    for (int i = 0; i < 6; i++) begin
      din = $urandom; idle(2);
    end
    idle(4);
    chk("R10 zero masks irq", {31'b0, irq}, 0);

    // R4 both mask bits: either edge on channel 3
    din = 0; wr(A_CTRL, C_OFF); wr(A_RISE, 32'h8); wr(A_FALL, 32'h8); idle(4);
    wr(A_CTRL, C_EDGE); idle(2);
    din[3] = 1'b1; idle(5);
    chk("R4 rise on dual", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R4 capt rise", v, 32'h8);
    chk("R8 irq cleared", {31'b0, irq}, 0);
    din[3] = 1'b0; idle(5);
    chk("R4 fall on dual", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R4 capt fall", v, 32'h8);

    // R5 accumulation while pending
    wr(A_RISE, 32'h0003); wr(A_FALL, 0);
    din[0] = 1'b1; idle(5);
    din[1] = 1'b1; idle(5);
    chk("R5 irq held", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R5 merged capt", v, 32'h3);

    // R8 read racing a new event
    din[0] = 1'b0; din[1] = 1'b0; wr(A_FALL, 32'h0003); idle(4);
    rd(A_CAPT, v);
    din[0] = 1'b1; idle(5);               // channel 0 pending
    @(negedge clk); din[1] = 1'b1;        // edge lands with next read
    idle(1);
    rd(A_CAPT, v); chk("R8 first read", v, 32'h1);
    chk("R8 event kept irq", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R8 kept capt", v, 32'h2);

    // R9 disable drops irq and blocks events
    din[0] = 1'b0; idle(5);
    chk("R9 pending before", {31'b0, irq}, 1);
    wr(A_CTRL, C_OFF);
    chk("R9 irq dropped", {31'b0, irq}, 0);
    din[0] = 1'b1; idle(5);
    chk("R9 blocked irq", {31'b0, irq}, 0);
    rd(A_CAPT, v); chk("R9 capt empty", v, 0);

    // R4 random edge trials
    for (int t = 0; t < 30; t++) begin
      logic [15:0] m1, m2, a, b, e;
      m1 = 16'($urandom); m2 = 16'($urandom);
      a = 16'($urandom); b = 16'($urandom);
      e = edge_exp(m1, m2, a, b);
      wr(A_CTRL, C_OFF); wr(A_RISE, {16'b0, m1}); wr(A_FALL, {16'b0, m2});
      din = {16'($urandom), a}; idle(5);
      wr(A_CTRL, C_EDGE); idle(3);
      din = {16'($urandom), b}; idle(5);
      chk("R4 random irq", {31'b0, irq}, {31'b0, e != 0});
      rd(A_CAPT, v); chk("R4 random capt", v, {16'b0, e});
    end

    // R6 / R7 random level trials
    for (int t = 0; t < 30; t++) begin
      logic [15:0] m1, m2, d;
      logic f;
      m1 = 16'($urandom); m2 = 16'($urandom) & ~m1;
      if (t % 5 == 0) m2 = m2 | (m1 & 16'($urandom));
      if (t % 2 == 0) d = m1 | (16'($urandom) & ~m1 & ~m2);
      else            d = 16'($urandom);
      f = level_exp(m1, m2, d);
      wr(A_CTRL, C_OFF);
      din = {16'($urandom), d}; idle(5);
      wr(A_RISE, {16'b0, m1}); wr(A_FALL, {16'b0, m2});
      wr(A_CTRL, C_LEVEL); idle(4);
      chk("R6 random irq", {31'b0, irq}, {31'b0, f});
      rd(A_CAPT, v); chk("R6 random capt", v, f ? {16'b0, m1 | m2} : 32'h0);
      idle(5);
      chk("R7 no refire while met", {31'b0, irq}, 0);
    end

    // R7 directed: break and restore re-arms
    wr(A_CTRL, C_OFF); din = 32'h0000_0005; idle(5);
    wr(A_RISE, 32'h5); wr(A_FALL, 32'h2);
    wr(A_CTRL, C_LEVEL); idle(4);
    chk("R6 directed irq", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R6 directed capt", v, 32'h7);
    din[1] = 1'b1; idle(5);
    chk("R7 broken no irq", {31'b0, irq}, 0);
    din[1] = 1'b0; idle(5);
    chk("R7 refire after release", {31'b0, irq}, 1);
    rd(A_CAPT, v); chk("R7 refire capt", v, 32'h7);

    finish_run();
  end
endmodule